// File: doc/BRIEF.md
# UART Register Front End with Prioritized Interrupt

This block is the processor-facing register set of a 16550-style serial port. A 32-bit, word-addressed slave bus with separate read and write strobes reaches eight registers. A received byte arrives on a byte-wide valid/ready stream and waits in a single holding byte. A write to the data register sends its low byte out on a transmit stream as a one-cycle valid pulse. The block raises one level-sensitive interrupt line. The active cause is chosen by fixed priority and can be read back as an identification code.

The holding byte is a small state machine with two states, HOLD_EMPTY and HOLD_FULL. The CAPTURE transition goes from HOLD_EMPTY to HOLD_FULL when a byte arrives. The OVERWRITE transition stays in HOLD_FULL when a byte arrives before the old one was read, and it flags overrun. The DRAIN transition goes from HOLD_FULL to HOLD_EMPTY when the data register is read and no byte arrives in the same cycle. The stay transitions hold the current state when nothing happens. The interrupt cause takes one of five values: CAUSE_LINE, CAUSE_RXDATA, CAUSE_TXEMPTY, CAUSE_MODEM and CAUSE_NONE. It is recomputed from the register state in every cycle.

Serial bit timing is out of scope, and so are parity and the modem pins. The line-control, modem-control and divisor values are stored and driven out to the serial engine. The modem status register reads as zero.

Top module: `uart_regfile`

## Requirements
- R1: After reset the following hold. The holding byte, interrupt enable, line control, modem control and divisor are all zero. Line status reads 0x60 and ident reads 0x1. The outputs irq and tx_valid are low, and rx_ready is high.
- R2: The register is selected by word offset bus_addr[4:2]. The offsets are 0 data, 1 interrupt enable, 2 ident, 3 line control, 4 modem control, 5 line status, 6 modem status and 7 divisor. Any address with a nonzero bit at or above bit 5 is unmapped: it reads 0 and writes to it are ignored.
- R3: The write-only registers are interrupt enable (bits 3:0), line control (bits 7:0), modem control (bits 7:0) and divisor (bits DIV_W-1:0). A write takes effect on the next cycle and appears on line_ctrl, modem_ctrl and divisor. Reads of these registers return 0.
- R4: Writes to ident, line status and modem status change nothing. Modem status always reads 0.
- R5: A byte with rx_valid high is captured at the clock edge, and data ready (line status bit 0) is then set. rx_ready is high exactly while data ready is clear. A read of the data register returns the held byte in bits 7:0. That read clears data ready, unless a new byte arrives in the same cycle.
- R6: A byte can arrive while data ready is set and the data register is not read in that cycle. The overrun bit (line status bit 1) is then set, the new byte replaces the old one, and data ready stays set.
- R7: Line status bit 5 (holding empty) and bit 6 (transmitter empty) always read 1. Bits 4:2 read 0. A line-status read clears overrun after the read, unless a new overrun occurs in the same cycle.
- R8: A write to the data register makes tx_valid high for exactly the next cycle, with tx_data equal to bus_wdata[7:0]. Back-to-back writes each give their own pulse.
- R9: The ident value is chosen by priority. Overrun with enable bit 2 gives 0x6. Otherwise data ready with enable bit 0 gives 0x4. Otherwise enable bit 1 gives 0x2, because holding empty is always set. Otherwise a nonzero modem status low nibble with enable bit 3 gives 0x0. Otherwise the ident is 0x1. irq is high exactly when the ident is not 0x1.
- R10: ident and irq reflect the new state in the cycle right after a bus access or a received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | High while the holding byte is empty |
| tx_valid | output | 1 | One-cycle pulse per transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| line_ctrl | output | 8 | Stored line-control value |
| modem_ctrl | output | 8 | Stored modem-control value |
| divisor | output | DIV_W | Stored divisor value |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults, ADDR_W = 6 and DIV_W = 16. The sixth address bit puts offsets 8 to 15 within reach, so unmapped reads and ignored writes are exercised next to the eight real registers. The 16-bit divisor shows that write data above the stored width is dropped. The random mix presents bytes without regard to rx_ready. This reaches overrun, a data read in the same cycle as an arrival, and a line-status read in the same cycle as an overrun. The directed steps walk the interrupt ident through each priority level.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

    localparam int REG_SEL_W = 3;
    localparam int SEL_LO    = 2;
    localparam int SEL_HI    = SEL_LO + REG_SEL_W - 1;

    typedef enum logic [REG_SEL_W-1:0] {
        OFF_DATA      = 3'd0,
        OFF_IEN       = 3'd1,
        OFF_IDENT     = 3'd2,
        OFF_LINECTL   = 3'd3,
        OFF_MODEMCTL  = 3'd4,
        OFF_LINESTAT  = 3'd5,
        OFF_MODEMSTAT = 3'd6,
        OFF_DIVISOR   = 3'd7
    } reg_off_e;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_e;

    typedef enum logic [2:0] {
        CAUSE_LINE,
        CAUSE_RXDATA,
        CAUSE_TXEMPTY,
        CAUSE_MODEM,
        CAUSE_NONE
    } cause_e;

    localparam logic [3:0] ID_LINE    = 4'h6;
    localparam logic [3:0] ID_RXDATA  = 4'h4;
    localparam logic [3:0] ID_TXEMPTY = 4'h2;
    localparam logic [3:0] ID_MODEM   = 4'h0;
    localparam logic [3:0] ID_NONE    = 4'h1;

endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_regfile_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              data_read,
    input  logic              stat_read,
    output logic              rx_ready,
    output logic              data_ready,
    output logic              overrun,
    output logic [BYTE_W-1:0] hold_byte
);

    hold_state_e state_q, state_d;
    logic        ovr_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: begin
                if (rx_valid) begin
                    state_d = HOLD_FULL;
                end
            end
            HOLD_FULL: begin
                if (data_read && !rx_valid) begin
                    state_d = HOLD_EMPTY;
                end
            end
        endcase
    end

    always_comb begin
        data_ready = (state_q == HOLD_FULL);
        rx_ready   = (state_q == HOLD_EMPTY);
        ovr_set    = rx_valid && (state_q == HOLD_FULL) && !data_read;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun   <= 1'b0;
            hold_byte <= '0;
        end else begin
            if (ovr_set) begin
                overrun <= 1'b1;
            end else if (stat_read) begin
                overrun <= 1'b0;
            end
            if (rx_valid) begin
                hold_byte <= rx_byte;
            end
        end
    end

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && data_ready && !data_read) |=> overrun); // R6
    AST_READY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read && !rx_valid) |=> rx_ready); // R5
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (data_ready && hold_byte == $past(rx_byte))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(hold_byte)); // R5

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_regfile_pkg::*;
(
    input  logic [3:0] ien,
    input  logic       line_err,
    input  logic       data_ready,
    input  logic       tx_empty,
    input  logic [3:0] modem_delta,
    output logic [3:0] ident,
    output logic       irq
);

    cause_e cause;

    always_comb begin
        if (ien[2] && line_err) begin
            cause = CAUSE_LINE;
        end else if (ien[0] && data_ready) begin
            cause = CAUSE_RXDATA;
        end else if (ien[1] && tx_empty) begin
            cause = CAUSE_TXEMPTY;
        end else if (ien[3] && (modem_delta != 4'h0)) begin
            cause = CAUSE_MODEM;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    always_comb begin
        unique case (cause)
            CAUSE_LINE:    ident = ID_LINE;
            CAUSE_RXDATA:  ident = ID_RXDATA;
            CAUSE_TXEMPTY: ident = ID_TXEMPTY;
            CAUSE_MODEM:   ident = ID_MODEM;
            default:       ident = ID_NONE;
        endcase
        irq = (cause != CAUSE_NONE);
    end

endmodule

// File: rtl/uart_tx_port.sv
module uart_tx_port #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [BYTE_W-1:0] send_byte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= send;
            if (send) begin
                tx_data <= send_byte;
            end
        end
    end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regfile_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic [7:0]        line_ctrl,
    output logic [7:0]        modem_ctrl,
    output logic [DIV_W-1:0]  divisor,
    output logic              irq
);

    localparam int         BUS_W      = 32;
    localparam logic [7:0] MODEM_STAT = 8'h00;

    reg_off_e   off;
    logic       mapped;
    logic       wr_hit, rd_hit;
    logic [3:0] ien_q;
    logic       data_ready, overrun;
    logic [7:0] hold_byte;
    logic [7:0] line_stat;
    logic [3:0] ident;
    logic       bus_unused;

    assign off = reg_off_e'(bus_addr[SEL_HI:SEL_LO]);

    generate
        if (ADDR_W > SEL_HI + 1) begin : g_upper_decode
            assign mapped = ~|bus_addr[ADDR_W-1:SEL_HI+1];
        end else begin : g_full_decode
            assign mapped = 1'b1;
        end
    endgenerate

    assign bus_unused = ^{bus_addr[SEL_LO-1:0], bus_wdata[BUS_W-1:DIV_W]};
    assign wr_hit     = bus_wr && mapped;
    assign rd_hit     = bus_rd && mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q      <= '0;
            line_ctrl  <= '0;
            modem_ctrl <= '0;
            divisor    <= '0;
        end else if (wr_hit) begin
            unique case (off)
                OFF_IEN:      ien_q      <= bus_wdata[3:0];
                OFF_LINECTL:  line_ctrl  <= bus_wdata[7:0];
                OFF_MODEMCTL: modem_ctrl <= bus_wdata[7:0];
                OFF_DIVISOR:  divisor    <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    uart_rx_hold #(.BYTE_W(8)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .data_read  (rd_hit && off == OFF_DATA),
        .stat_read  (rd_hit && off == OFF_LINESTAT),
        .rx_ready   (rx_ready),
        .data_ready (data_ready),
        .overrun    (overrun),
        .hold_byte  (hold_byte)
    );

    assign line_stat = {1'b0, 1'b1, 1'b1, 3'b000, overrun, data_ready};

    uart_irq_prio u_prio (
        .ien         (ien_q),
        .line_err    (|line_stat[4:1]),
        .data_ready  (data_ready),
        .tx_empty    (line_stat[5]),
        .modem_delta (MODEM_STAT[3:0]),
        .ident       (ident),
        .irq         (irq)
    );

    uart_tx_port #(.BYTE_W(8)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (wr_hit && off == OFF_DATA),
        .send_byte (bus_wdata[7:0]),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (off)
                OFF_DATA:      bus_rdata[7:0] = hold_byte;
                OFF_IDENT:     bus_rdata[3:0] = ident;
                OFF_LINESTAT:  bus_rdata[7:0] = line_stat;
                OFF_MODEMSTAT: bus_rdata[7:0] = MODEM_STAT;
                default:       bus_rdata      = '0;
            endcase
        end
    end

    AST_TX_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mapped && off == OFF_DATA) |=> (tx_valid && tx_data == $past(bus_wdata[7:0]))); // R8
    AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && mapped && off == OFF_DATA) |=> !tx_valid); // R8
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 4'h0) |-> !irq); // R9
    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[2] && overrun) |-> (ident == ID_LINE)); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |-> (bus_rdata == 32'h0)); // R2

endmodule

// File: tb/uart_regfile_test.sv
module uart_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data, line_ctrl, modem_ctrl;
    logic [15:0] divisor;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic        m_dr, m_oe;
    logic [7:0]  m_hold, m_lcr, m_mcr;
    logic [3:0]  m_ien;
    logic [15:0] m_div;

    always #5 clk = ~clk;

    uart_regfile #(.ADDR_W(6), .DIV_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .line_ctrl(line_ctrl),
        .modem_ctrl(modem_ctrl), .divisor(divisor), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    function automatic logic [3:0] exp_ident();
        if (m_ien[2] && m_oe) return 4'h6;
        if (m_ien[0] && m_dr) return 4'h4;
        if (m_ien[1])         return 4'h2;
        return 4'h1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] o, input logic mp);
        if (!mp) return 32'h0;
        case (o)
            3'd0:    return {24'h0, m_hold};
            3'd2:    return {28'h0, exp_ident()};
            3'd5:    return {24'h0, 8'h60 | {6'h0, m_oe, m_dr}};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] o, input logic mp);
        if (!mp) return "R2 unmapped read";
        case (o)
            3'd0:    return "R5 data read";
            3'd2:    return "R9 ident read";
            3'd5:    return "R7 line status read";
            3'd6:    return "R4 modem status read";
            default: return "R3 write-only read";
        endcase
    endfunction

    task automatic step(input logic wr, input logic rd, input logic [5:0] a,
                        input logic [31:0] wd, input logic rv, input logic [7:0] rb);
        logic [2:0] o;
        logic       mp, dread, sread, sent;
        o  = a[4:2];
        mp = !a[5];
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        rx_valid = rv; rx_byte = rb;
        #1;
        chk("R5 rx_ready", {31'h0, rx_ready}, {31'h0, !m_dr});
        if (rd) chk(read_tag(o, mp), bus_rdata, exp_read(o, mp));
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0;
        dread = rd && mp && (o == 3'd0);
        sread = rd && mp && (o == 3'd5);
        sent  = wr && mp && (o == 3'd0);
        m_oe  = (rv && m_dr && !dread) || (m_oe && !sread);
        m_dr  = rv || (m_dr && !dread);
        if (rv) m_hold = rb;
        if (wr && mp) begin
            case (o)
                3'd1: m_ien = wd[3:0];
                3'd3: m_lcr = wd[7:0];
                3'd4: m_mcr = wd[7:0];
                3'd7: m_div = wd[15:0];
                default: ;
            endcase
        end
        chk("R8 tx_valid", {31'h0, tx_valid}, {31'h0, sent});
        if (sent) chk("R8 tx_data", {24'h0, tx_data}, {24'h0, wd[7:0]});
        chk("R10 irq after access", {31'h0, irq}, {31'h0, exp_ident() != 4'h1});
        chk("R3 control outputs", {line_ctrl, modem_ctrl, divisor}, {m_lcr, m_mcr, m_div});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        m_dr = 0; m_oe = 0; m_hold = 0; m_lcr = 0; m_mcr = 0; m_ien = 0; m_div = 0;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        chk("R1 ctrl", {line_ctrl, modem_ctrl, divisor}, 32'h0);
        for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 6'(i * 4), 32'h0, 1'b0, 8'h0);

        // R3 write-only storage, wide divisor write truncated
        step(1'b1, 1'b0, 6'h0C, 32'hFFFF_FF5A, 1'b0, 8'h0);
        step(1'b1, 1'b0, 6'h10, 32'h0000_00C3, 1'b0, 8'h0);
        step(1'b1, 1'b0, 6'h1C, 32'hABCD_1234, 1'b0, 8'h0);
        step(1'b0, 1'b1, 6'h1C, 32'h0, 1'b0, 8'h0);
        // R2 unmapped write does not reach line control
        step(1'b1, 1'b0, 6'h2C, 32'h0000_0011, 1'b0, 8'h0);
        // R9 priority walk: enable everything, holding-empty cause first
        step(1'b1, 1'b0, 6'h04, 32'h0000_000F, 1'b0, 8'h0);
        step(1'b0, 1'b1, 6'h08, 32'h0, 1'b0, 8'h0);
        // R10 byte arrival raises receive cause
        step(1'b0, 1'b0, 6'h00, 32'h0, 1'b1, 8'hA5);
        step(1'b0, 1'b1, 6'h08, 32'h0, 1'b0, 8'h0);
        // R6 overrun, then R7 clear on line-status read
        step(1'b0, 1'b0, 6'h00, 32'h0, 1'b1, 8'h3C);
        step(1'b0, 1'b1, 6'h08, 32'h0, 1'b0, 8'h0);
        step(1'b0, 1'b1, 6'h14, 32'h0, 1'b0, 8'h0);
        step(1'b0, 1'b1, 6'h14, 32'h0, 1'b0, 8'h0);
        // R4 writes to read-only registers ignored
        step(1'b1, 1'b0, 6'h14, 32'hFFFF_FFFF, 1'b0, 8'h0);
        step(1'b1, 1'b0, 6'h08, 32'hFFFF_FFFF, 1'b0, 8'h0);
        step(1'b1, 1'b0, 6'h18, 32'hFFFF_FFFF, 1'b0, 8'h0);
        step(1'b0, 1'b1, 6'h14, 32'h0, 1'b0, 8'h0);
        step(1'b0, 1'b1, 6'h18, 32'h0, 1'b0, 8'h0);
        // R5 data read concurrent with arrival keeps data ready, no overrun
        step(1'b0, 1'b1, 6'h00, 32'h0, 1'b1, 8'h77);
        step(1'b0, 1'b1, 6'h14, 32'h0, 1'b0, 8'h0);
        // R7 line-status read concurrent with new overrun keeps overrun
        step(1'b0, 1'b1, 6'h14, 32'h0, 1'b1, 8'h88);
        step(1'b0, 1'b1, 6'h14, 32'h0, 1'b0, 8'h0);
        step(1'b0, 1'b1, 6'h00, 32'h0, 1'b0, 8'h0);
        // R8 back-to-back transmit writes
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 6'h00, 32'h100 + 32'(i * 17), 1'b0, 8'h0);
        // R9 disabled interrupts keep irq low
        step(1'b1, 1'b0, 6'h04, 32'h0, 1'b1, 8'h01);
        step(1'b0, 1'b1, 6'h08, 32'h0, 1'b1, 8'h02);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [5:0] a;
            op = int'($urandom % 3);
            a  = {($urandom % 8) == 0, 3'($urandom), 2'($urandom)};
            step(op == 1, op == 2, a, $urandom, ($urandom % 3) == 0, 8'($urandom));
        end
        finish_run();
    end

endmodule